// File: doc/BRIEF.md
# Programmable Wait-State Bus Controller

This block joins a processor-side bus master to a synchronous memory and stretches every access by a number of wait cycles that is set at run time. Boot software writes a latency value and a mode bit into a small configuration register. The value it writes depends on how fast the attached memory is. After that, each accepted request drives the memory's chip select, address, write enable and write data. The block then holds the master in a busy state until the access may end.

The mode bit decides what ends an access. In counted mode, a countdown timer is loaded from the latency register when the access starts, and the access ends when the timer runs out. In handshake mode, the controller waits for the memory to raise its own ready strobe. Each access keeps the configuration it started with. When an access finishes, the master receives a one-cycle completion pulse, and read data is valid in that same cycle.

Top module: `wsbc_top`

## Requirements
- R1: While reset is held and directly after it, m_wait, m_done and mem_cs are 0 and m_rdata is all zeros.
- R2: In counted mode (mode bit 0), an access with latency L keeps mem_cs high for exactly L+1 cycles. m_done is high in the cycle after the last mem_cs cycle.
- R3: A latency of 0 gives an access with exactly one mem_cs cycle and no wait cycles.
- R4: In handshake mode (mode bit 1), the access ends at the first clock edge that samples mem_rdy high while mem_cs is high. The latency value has no effect in this mode.
- R5: On a read, m_rdata takes the value mem_rdata had in the last mem_cs cycle. It is valid in the m_done cycle and holds until the next read completes; a write leaves it unchanged.
- R6: During a write access mem_we is 1 and mem_wdata equals the requested write data. During a read access mem_we is 0.
- R7: mem_addr equals the requested address and stays stable for every cycle of the access.
- R8: A configuration write made while an access is in flight does not change the length or the mode of that access. It takes effect from the next access.
- R9: A request is accepted only when m_wait is 0. Requests and master-side inputs that arrive while m_wait is 1 are ignored.
- R10: m_done is a pulse one cycle wide.
- R11: In counted mode, mem_rdy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_lat | input | LAT_W | Latency value (wait cycles) |
| cfg_mode | input | 1 | 0 = counted, 1 = handshake |
| m_req | input | 1 | Master access request |
| m_addr | input | AW | Master address |
| m_wdata | input | DW | Master write data |
| m_we | input | 1 | Master write enable (1 = write) |
| m_rdata | output | DW | Read data to master |
| m_done | output | 1 | One-cycle completion pulse |
| m_wait | output | 1 | Busy; master must hold off |
| mem_cs | output | 1 | Memory chip select |
| mem_addr | output | AW | Memory address |
| mem_we | output | 1 | Memory write enable |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data |
| mem_rdy | input | 1 | Memory ready strobe (handshake mode) |

## Verification
The assertions assume the following about the memory and the master:
- A memory in handshake mode eventually raises mem_rdy.
- The master presents a request only together with valid address and data.
- Configuration writes arrive as single-cycle strobes.

The stimulus keeps within these limits in three ways:
- It raises mem_rdy after a chosen delay in handshake mode and toggles it at random in counted mode.
- It drives junk requests and configuration writes only while an access is in flight, which is where they must be ignored.
- It ends every configuration strobe after one edge.

// File: rtl/wsbc_pkg.sv
package wsbc_pkg;
   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_BUSY = 1'b1
   } wsbc_state_e;

   typedef enum logic {
      MODE_COUNT = 1'b0,
      MODE_READY = 1'b1
   } wsbc_mode_e;
endpackage

// File: rtl/wsbc_cfg.sv
module wsbc_cfg
   import wsbc_pkg::*;
#(
   parameter int LAT_W     = 4,
   parameter int RESET_LAT = 3,
   parameter bit HS_EN     = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [LAT_W-1:0] lat_in,
   input  logic             mode_in,
   output logic [LAT_W-1:0] lat_q,
   output wsbc_mode_e       mode_q
);
   localparam logic [LAT_W-1:0] LAT_RST = LAT_W'(RESET_LAT);

   always_ff @(posedge clk) begin
      if (!rst_n)   lat_q <= LAT_RST;
      else if (wr)  lat_q <= lat_in;
   end

   generate
      if (HS_EN) begin : g_mode_reg
         always_ff @(posedge clk) begin
            if (!rst_n)  mode_q <= MODE_COUNT;
            else if (wr) mode_q <= wsbc_mode_e'(mode_in);
         end
      end else begin : g_mode_fixed
         assign mode_q = MODE_COUNT;
      end
   endgenerate
endmodule

// File: rtl/wsbc_timer.sv
module wsbc_timer #(
   parameter int LAT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [LAT_W-1:0] load_val,
   input  logic             dec,
   output logic             zero
);
   logic [LAT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)                    cnt_q <= '0;
      else if (load)                 cnt_q <= load_val;
      else if (dec && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
   end

   assign zero = (cnt_q == '0);
endmodule

// File: rtl/wsbc_fsm.sv
module wsbc_fsm
   import wsbc_pkg::*;
#(
   parameter int AW = 16,
   parameter int DW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] wdata,
   input  logic          we,
   input  wsbc_mode_e    mode_cur,
   input  logic          timer_zero,
   input  logic          mem_rdy,
   input  logic [DW-1:0] mem_rdata,
   output logic          start,
   output logic          dec,
   output logic          busy,
   output logic          done,
   output logic [DW-1:0] rdata,
   output logic [AW-1:0] mem_addr,
   output logic          mem_we,
   output logic [DW-1:0] mem_wdata
);
   wsbc_state_e   state_q;
   wsbc_mode_e    mode_snap_q;
   logic [AW-1:0] addr_q;
   logic [DW-1:0] wdata_q;
   logic          we_q;
   logic          finish;

   assign busy   = (state_q == ST_BUSY);
   assign start  = (state_q == ST_IDLE) && req;
   assign finish = busy && ((mode_snap_q == MODE_READY) ? mem_rdy : timer_zero);
   assign dec    = busy && !finish;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         mode_snap_q <= MODE_COUNT;
         addr_q      <= '0;
         wdata_q     <= '0;
         we_q        <= 1'b0;
         done        <= 1'b0;
         rdata       <= '0;
      end else begin
         done <= finish;
         if (start) begin
            state_q     <= ST_BUSY;
            mode_snap_q <= mode_cur;
            addr_q      <= addr;
            wdata_q     <= wdata;
            we_q        <= we;
         end else if (finish) begin
            state_q <= ST_IDLE;
            if (!we_q) rdata <= mem_rdata;
         end
      end
   end

   assign mem_addr  = addr_q;
   assign mem_we    = busy && we_q;
   assign mem_wdata = wdata_q;
endmodule

// File: rtl/wsbc_top.sv
module wsbc_top
   import wsbc_pkg::*;
#(
   parameter int AW        = 16,
   parameter int DW        = 32,
   parameter int LAT_W     = 4,
   parameter int RESET_LAT = 3,
   parameter bit HS_EN     = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic [LAT_W-1:0] cfg_lat,
   input  logic             cfg_mode,
   input  logic             m_req,
   input  logic [AW-1:0]    m_addr,
   input  logic [DW-1:0]    m_wdata,
   input  logic             m_we,
   output logic [DW-1:0]    m_rdata,
   output logic             m_done,
   output logic             m_wait,
   output logic             mem_cs,
   output logic [AW-1:0]    mem_addr,
   output logic             mem_we,
   output logic [DW-1:0]    mem_wdata,
   input  logic [DW-1:0]    mem_rdata,
   input  logic             mem_rdy
);
   localparam int LAT_MAX = (1 << LAT_W) - 1;

   generate
      if (AW < 1 || DW < 1) begin : g_bad_width
         $error("wsbc_top: AW and DW must be at least 1");
      end
      if (LAT_W < 1 || LAT_W > 16) begin : g_bad_latw
         $error("wsbc_top: LAT_W must be 1..16");
      end
      if (RESET_LAT < 0 || RESET_LAT > LAT_MAX) begin : g_bad_rst
         $error("wsbc_top: RESET_LAT does not fit LAT_W");
      end
   endgenerate

   logic [LAT_W-1:0] lat_q;
   wsbc_mode_e       mode_q;
   logic             start, dec, busy, tzero;

   wsbc_cfg #(.LAT_W(LAT_W), .RESET_LAT(RESET_LAT), .HS_EN(HS_EN)) u_cfg (
      .clk(clk), .rst_n(rst_n), .wr(cfg_we), .lat_in(cfg_lat),
      .mode_in(cfg_mode), .lat_q(lat_q), .mode_q(mode_q)
   );

   wsbc_timer #(.LAT_W(LAT_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .load(start), .load_val(lat_q),
      .dec(dec), .zero(tzero)
   );

   wsbc_fsm #(.AW(AW), .DW(DW)) u_fsm (
      .clk(clk), .rst_n(rst_n), .req(m_req), .addr(m_addr), .wdata(m_wdata),
      .we(m_we), .mode_cur(mode_q), .timer_zero(tzero), .mem_rdy(mem_rdy),
      .mem_rdata(mem_rdata), .start(start), .dec(dec), .busy(busy),
      .done(m_done), .rdata(m_rdata), .mem_addr(mem_addr), .mem_we(mem_we),
      .mem_wdata(mem_wdata)
   );

   assign m_wait = busy;
   assign mem_cs = busy;
endmodule

// File: rtl/wsbc_chk.sv
module wsbc_chk #(
   parameter int AW        = 16,
   parameter int DW        = 32,
   parameter int LAT_W     = 4,
   parameter int RESET_LAT = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cfg_we,
   input logic [LAT_W-1:0] cfg_lat,
   input logic             cfg_mode,
   input logic             m_req,
   input logic [DW-1:0]    m_rdata,
   input logic             m_done,
   input logic             m_wait,
   input logic             mem_cs,
   input logic [AW-1:0]    mem_addr,
   input logic             mem_we,
   input logic [DW-1:0]    mem_rdata,
   input logic             mem_rdy
);
   localparam int CW = LAT_W + 2;

   logic [LAT_W-1:0] sh_lat, snap_lat;
   logic             sh_mode, snap_mode;
   logic [CW-1:0]    cs_cnt;
   logic             accept;

   assign accept = m_req && !m_wait;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sh_lat    <= LAT_W'(RESET_LAT);
         sh_mode   <= 1'b0;
         snap_lat  <= '0;
         snap_mode <= 1'b0;
         cs_cnt    <= '0;
      end else begin
         if (cfg_we) begin
            sh_lat  <= cfg_lat;
            sh_mode <= cfg_mode;
         end
         if (accept) begin
            snap_lat  <= sh_lat;
            snap_mode <= sh_mode;
            cs_cnt    <= '0;
         end else if (mem_cs) begin
            cs_cnt <= cs_cnt + 1'b1;
         end
      end
   end

   // R2 / R3 / R8: counted accesses last latency+1 chip-select cycles
   p_count_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (m_done && !snap_mode) |-> (cs_cnt == CW'(snap_lat) + CW'(1)));

   // R4: handshake access ends only after ready was sampled
   p_ready_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (m_done && snap_mode) |-> $past(mem_rdy));

   p_rdata_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (m_done && $past(mem_cs && !mem_we)) |-> (m_rdata == $past(mem_rdata)));

   p_addr_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_cs && $past(mem_cs)) |-> ($stable(mem_addr) && $stable(mem_we)));

   p_start_on_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_cs) |-> $past(m_req));

   p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      m_done |=> !m_done);

   p_done_after_cs_r10: assert property (@(posedge clk) disable iff (!rst_n)
      m_done |-> ($past(mem_cs) && !m_wait));
endmodule

bind wsbc_top wsbc_chk #(
   .AW(AW), .DW(DW), .LAT_W(LAT_W), .RESET_LAT(RESET_LAT)
) u_chk (
   .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_lat(cfg_lat),
   .cfg_mode(cfg_mode), .m_req(m_req), .m_rdata(m_rdata), .m_done(m_done),
   .m_wait(m_wait), .mem_cs(mem_cs), .mem_addr(mem_addr), .mem_we(mem_we),
   .mem_rdata(mem_rdata), .mem_rdy(mem_rdy)
);

// File: tb/wsbc_top_tb.sv
module wsbc_top_tb;
   localparam int AW = 16;
   localparam int DW = 32;
   localparam int LW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_we = 1'b0;
   logic [LW-1:0] cfg_lat = '0;
   logic          cfg_mode = 1'b0;
   logic          m_req = 1'b0;
   logic [AW-1:0] m_addr = '0;
   logic [DW-1:0] m_wdata = '0;
   logic          m_we = 1'b0;
   logic [DW-1:0] m_rdata;
   logic          m_done, m_wait, mem_cs, mem_we;
   logic [AW-1:0] mem_addr;
   logic [DW-1:0] mem_wdata;
   logic [DW-1:0] mem_rdata = '0;
   logic          mem_rdy = 1'b0;

   int n_chk = 0;
   int n_bad = 0;

   logic [LW-1:0] sh_lat  = 4'd3;
   logic          sh_mode = 1'b0;

   always #2.5 clk = ~clk;

   wsbc_top #(.AW(AW), .DW(DW), .LAT_W(LW), .RESET_LAT(3), .HS_EN(1'b1)) u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_lat(cfg_lat),
      .cfg_mode(cfg_mode), .m_req(m_req), .m_addr(m_addr), .m_wdata(m_wdata),
      .m_we(m_we), .m_rdata(m_rdata), .m_done(m_done), .m_wait(m_wait),
      .mem_cs(mem_cs), .mem_addr(mem_addr), .mem_we(mem_we),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_rdy(mem_rdy)
   );

   function automatic logic [DW-1:0] data_fn(input logic [AW-1:0] a, input int k);
      return {a, a ^ 16'hA5C3} + DW'(k * 32'h0101_0013);
   endfunction

   function automatic int exp_len(input logic md, input logic [LW-1:0] lat, input int dly);
      return md ? dly + 1 : int'(lat) + 1;
   endfunction

   task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h at %0t", rq, act, exp, $time);
      end
   endtask

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
   endtask

   task automatic cfg_write(input logic [LW-1:0] lat, input logic md);
      @(negedge clk);
      cfg_we = 1'b1; cfg_lat = lat; cfg_mode = md;
      @(negedge clk);
      cfg_we = 1'b0;
      sh_lat = lat; sh_mode = md;
   endtask

   task automatic do_acc(input logic we, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                         input int dly, input bit chg);
      logic [LW-1:0] slat;
      logic          smode;
      logic [DW-1:0] last_rd, prev_rd;
      int            en, n;
      slat  = sh_lat;
      smode = sh_mode;
      en    = exp_len(smode, slat, dly);
      n     = 0;
      last_rd = '0;
      @(negedge clk);
      prev_rd = m_rdata;
      m_req = 1'b1; m_addr = a; m_wdata = wd; m_we = we; mem_rdy = 1'b0;
      forever begin
         @(negedge clk);
         if (mem_cs) begin
            n++;
            chk(mem_addr == a, "R7", longint'(mem_addr), longint'(a));
            chk(mem_we == we, "R6", longint'(mem_we), longint'(we));
            if (we) chk(mem_wdata == wd, "R6", longint'(mem_wdata), longint'(wd));
            chk(!m_done && m_wait, "R10", longint'({m_done, m_wait}), 64'h1);
            mem_rdata = data_fn(a, n);
            last_rd = mem_rdata;
            if (smode) mem_rdy = (n == dly + 1);
            else       mem_rdy = 1'($urandom % 2); // R11: ignored in counted mode
            if (n == 1) begin
               if (en >= 2) begin // R9: junk request while busy
                  m_req = 1'b1; m_addr = ~a; m_we = ~we; m_wdata = ~wd;
               end else m_req = 1'b0;
               if (chg) begin // R8: reconfigure mid-access
                  cfg_we = 1'b1;
                  cfg_lat = LW'($urandom);
                  cfg_mode = 1'($urandom);
                  sh_lat = cfg_lat; sh_mode = cfg_mode;
               end
            end else begin
               m_req = 1'b0; cfg_we = 1'b0;
            end
            if (n > 40) begin
               chk(1'b0, "R4", longint'(n), longint'(en));
               break;
            end
         end else begin
            m_req = 1'b0; cfg_we = 1'b0; mem_rdy = 1'b0;
            if (smode)          chk(n == en, "R4", longint'(n), longint'(en));
            else if (slat == 0) chk(n == en, "R3", longint'(n), longint'(en));
            else                chk(n == en, chg ? "R8" : "R2", longint'(n), longint'(en));
            chk(m_done, "R2", longint'(m_done), 64'h1);
            if (!we) chk(m_rdata == last_rd, "R5", longint'(m_rdata), longint'(last_rd));
            else     chk(m_rdata == prev_rd, "R5", longint'(m_rdata), longint'(prev_rd));
            break;
         end
      end
      @(negedge clk);
      chk(!m_done, "R10", longint'(m_done), 64'h0);
      chk(!mem_cs && !m_wait, "R9", longint'({mem_cs, m_wait}), 64'h0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      process::self().srandom(32'd1234);
      repeat (3) @(negedge clk);
      chk(!m_wait && !m_done && !mem_cs && m_rdata == '0, "R1",
          longint'({m_wait, m_done, mem_cs}), 64'h0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!m_wait && !m_done && !mem_cs && m_rdata == '0, "R1",
          longint'({m_wait, m_done, mem_cs}), 64'h0);

      // directed corner cases
      do_acc(1'b0, 16'h1234, 32'h0, 0, 1'b0);          // R2 reset latency 3
      cfg_write(4'd2, 1'b0);
      do_acc(1'b0, 16'h0042, 32'h0, 0, 1'b0);          // R2 latency 2
      cfg_write(4'd0, 1'b0);
      do_acc(1'b0, 16'h00F0, 32'h0, 0, 1'b0);          // R3 read
      do_acc(1'b1, 16'h00F1, 32'hDEAD_BEEF, 0, 1'b0);  // R3 write, R5 hold
      cfg_write(4'd15, 1'b0);
      do_acc(1'b1, 16'hFFFF, 32'h1357_9BDF, 0, 1'b1);  // R8 max latency
      cfg_write(4'd9, 1'b1);
      do_acc(1'b0, 16'h0A0A, 32'h0, 0, 1'b0);          // R4 immediate ready
      do_acc(1'b0, 16'h0B0B, 32'h0, 4, 1'b1);          // R4 delayed ready, R8
      cfg_write(4'd1, 1'b0);
      do_acc(1'b0, 16'h0C0C, 32'h0, 5, 1'b0);          // R11 ready ignored

      // random traffic
      for (int i = 0; i < 80; i++) begin
         if ($urandom % 4 == 0) cfg_write(LW'($urandom), 1'($urandom));
         do_acc(1'($urandom), AW'($urandom), DW'($urandom),
                int'($urandom % 7), 1'($urandom % 3 == 0));
      end

      summary();
      $finish;
   end
endmodule